// File: doc/BRIEF.md
# Six-Bit Controlled Arithmetic Logic Unit with Zero and Sign Flags

This block is a purely combinational arithmetic logic unit for a 16-bit datapath. It has no opcode field. Instead, six independent control bits set its function. Two of them condition the first operand and two condition the second: each operand can be cleared, bit-inverted, or both. One bit picks the core operation, either wrapping two's-complement addition or bitwise AND. The last bit can invert the core result before it leaves the block.

Combining these bits gives the usual set of functions: constants, pass-through, negation, increment, decrement, subtraction in both directions, AND and OR. The block also reports two flags on the final result, one for zero and one for negative. It has no clock and no reset. The surrounding logic supplies the operands and the control bits and consumes the outputs in the same cycle.

Top module: `alu16_ctl`

## Requirements
- R1: When `zero_x` is 1, the first operand is replaced by all zeros before any inversion.
- R2: When `inv_x` is 1, the (possibly cleared) first operand is bitwise inverted, so `zero_x`=1 with `inv_x`=1 gives all ones.
- R3: When `zero_y` is 1, the second operand is replaced by all zeros before any inversion.
- R4: When `inv_y` is 1, the (possibly cleared) second operand is bitwise inverted.
- R5: When `sel_add` is 1, the core result is the sum of the conditioned operands modulo 2^16, and no carry or overflow is reported.
- R6: When `sel_add` is 0, the core result is the bitwise AND of the conditioned operands.
- R7: When `inv_out` is 1, `result` is the bitwise inverse of the core result; otherwise it equals the core result.
- R8: `is_zero` is 1 exactly when all 16 bits of `result` are 0.
- R9: `is_neg` equals bit 15 of `result`, taken after any output inversion.
- R10: The outputs follow the inputs combinationally, with no clock and no state held between input changes.
- R11: With the control bits written as the 6-bit code {zero_x, inv_x, zero_y, inv_y, sel_add, inv_out} (MSB first), these codes give these results: 101010 gives 0, 111111 gives 1, 111010 gives -1, 001100 gives x, 110000 gives y, 000010 gives x+y, 010011 gives x-y, 000111 gives y-x, 000000 gives x AND y, and 010101 gives x OR y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | 16 | First operand |
| opnd_y | input | 16 | Second operand |
| zero_x | input | 1 | Clear first operand |
| inv_x | input | 1 | Invert first operand after clearing |
| zero_y | input | 1 | Clear second operand |
| inv_y | input | 1 | Invert second operand after clearing |
| sel_add | input | 1 | 1 selects addition, 0 selects bitwise AND |
| inv_out | input | 1 | Invert the core result |
| result | output | 16 | Final result |
| is_zero | output | 1 | Result is zero |
| is_neg | output | 1 | Result is negative (bit 15) |

## Verification
The rarest situations are the arithmetic edges: a sum that wraps exactly to zero and so must raise the zero flag, and a sum that crosses from the largest positive value into the sign bit. Random operands almost never land on these. Directed vectors therefore pick operands such as 0xFFFF plus 1 and 0x7FFF plus 1. Alongside these, a sweep drives every one of the 64 control codes with several random operand pairs and compares the outputs against a model computed separately in the bench.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned CTRL_W = 6;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic sel_add;
        logic inv_out;
    } alu_ctrl_t;

    typedef enum logic {
        CORE_AND = 1'b0,
        CORE_ADD = 1'b1
    } core_op_e;

    typedef struct packed {
        logic is_zero;
        logic is_neg;
    } alu_flags_t;

    // Clear first, then invert.
    function automatic word_t condition_word(input word_t v, input logic clr, input logic flip);
        word_t t;
        t = clr ? '0 : v;
        return flip ? ~t : t;
    endfunction

endpackage

// File: rtl/alu16_operand_prep.sv
module alu16_operand_prep #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] din,
    input  logic         clr,
    input  logic         flip,
    output logic [W-1:0] dout
);
    logic [W-1:0] cleared;

    always_comb begin
        cleared = clr ? '0 : din;
        dout    = flip ? ~cleared : cleared;
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  alu16_pkg::core_op_e op,
    output logic [W-1:0]       y
);
    logic [W-1:0] sum;
    logic [W-1:0] conj;

    always_comb begin
        sum  = a + b;
        conj = a & b;
        y    = (op == alu16_pkg::CORE_ADD) ? sum : conj;
    end
endmodule

// File: rtl/alu16_result_stage.sv
module alu16_result_stage #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]         core_y,
    input  logic                 flip,
    output logic [W-1:0]         y,
    output alu16_pkg::alu_flags_t flags
);
    always_comb begin
        y             = flip ? ~core_y : core_y;
        flags.is_zero = ~|y;
        flags.is_neg  = y[W-1];
    end
endmodule

// File: rtl/alu16_ctl.sv
module alu16_ctl
    import alu16_pkg::*;
(
    input  logic [15:0] opnd_x,
    input  logic [15:0] opnd_y,
    input  logic        zero_x,
    input  logic        inv_x,
    input  logic        zero_y,
    input  logic        inv_y,
    input  logic        sel_add,
    input  logic        inv_out,
    output logic [15:0] result,
    output logic        is_zero,
    output logic        is_neg
);
    localparam int unsigned NUM_OPND = 2;

    alu_ctrl_t  ctl;
    word_t      raw   [NUM_OPND];
    logic       clr_v [NUM_OPND];
    logic       flp_v [NUM_OPND];
    word_t      prep  [NUM_OPND];
    word_t      cond_x;
    word_t      cond_y;
    word_t      core_res;
    core_op_e   op;
    alu_flags_t flags;

    always_comb begin
        ctl = '{zero_x: zero_x, inv_x: inv_x, zero_y: zero_y,
                inv_y: inv_y, sel_add: sel_add, inv_out: inv_out};
        raw[0]   = opnd_x;
        raw[1]   = opnd_y;
        clr_v[0] = ctl.zero_x;
        clr_v[1] = ctl.zero_y;
        flp_v[0] = ctl.inv_x;
        flp_v[1] = ctl.inv_y;
        op       = core_op_e'(ctl.sel_add);
    end

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_prep
        alu16_operand_prep #(.W(DATA_W)) u_prep (
            .din  (raw[i]),
            .clr  (clr_v[i]),
            .flip (flp_v[i]),
            .dout (prep[i])
        );
    end

    assign cond_x = prep[0];
    assign cond_y = prep[1];

    alu16_core #(.W(DATA_W)) u_core (
        .a  (cond_x),
        .b  (cond_y),
        .op (op),
        .y  (core_res)
    );

    alu16_result_stage #(.W(DATA_W)) u_post (
        .core_y (core_res),
        .flip   (ctl.inv_out),
        .y      (result),
        .flags  (flags)
    );

    assign is_zero = flags.is_zero;
    assign is_neg  = flags.is_neg;
endmodule

// File: rtl/alu16_ctl_chk.sv
module alu16_ctl_chk (
    input logic [15:0] opnd_x,
    input logic [15:0] opnd_y,
    input logic        zero_x,
    input logic        inv_x,
    input logic        zero_y,
    input logic        inv_y,
    input logic        sel_add,
    input logic        inv_out,
    input logic [15:0] cond_x,
    input logic [15:0] cond_y,
    input logic [15:0] result,
    input logic        is_zero,
    input logic        is_neg
);
    logic known;

    always_comb begin
        known = !$isunknown({opnd_x, opnd_y, zero_x, inv_x, zero_y, inv_y, sel_add, inv_out});
        if (known) begin
            // R1
            p_clear_x_r1: assert (!(zero_x && !inv_x) || cond_x == 16'h0000);
            // R2
            p_clear_inv_x_r2: assert (!(zero_x && inv_x) || cond_x == 16'hFFFF);
            // R3
            p_clear_y_r3: assert (!(zero_y && !inv_y) || cond_y == 16'h0000);
            // R4
            p_pass_inv_y_r4: assert (!(!zero_y && inv_y) || cond_y == ~opnd_y);
            // R5 and R7
            p_add_path_r5: assert (!sel_add || (inv_out ? ~result : result) == 16'(cond_x + cond_y));
            // R6 and R7
            p_and_path_r6: assert (sel_add || (inv_out ? ~result : result) == (cond_x & cond_y));
            // R8 and R9
            p_flags_excl_r8: assert (!(is_zero && is_neg));
            // R9
            p_sign_r9: assert (!is_neg || result >= 16'h8000);
        end
    end
endmodule

bind alu16_ctl alu16_ctl_chk u_chk (
    .opnd_x  (opnd_x),
    .opnd_y  (opnd_y),
    .zero_x  (zero_x),
    .inv_x   (inv_x),
    .zero_y  (zero_y),
    .inv_y   (inv_y),
    .sel_add (sel_add),
    .inv_out (inv_out),
    .cond_x  (cond_x),
    .cond_y  (cond_y),
    .result  (result),
    .is_zero (is_zero),
    .is_neg  (is_neg)
);

// File: tb/tb_alu16_ctl.sv
module tb_alu16_ctl;

    logic        clk = 1'b0;
    logic [15:0] opnd_x = '0;
    logic [15:0] opnd_y = '0;
    logic [5:0]  code = '0;
    logic [15:0] result;
    logic        is_zero;
    logic        is_neg;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu16_ctl dut (
        .opnd_x  (opnd_x),
        .opnd_y  (opnd_y),
        .zero_x  (code[5]),
        .inv_x   (code[4]),
        .zero_y  (code[3]),
        .inv_y   (code[2]),
        .sel_add (code[1]),
        .inv_out (code[0]),
        .result  (result),
        .is_zero (is_zero),
        .is_neg  (is_neg)
    );

    typedef struct packed {
        logic [5:0]  c;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    // R11: named codes with x=5, y=3
    localparam vec_t VECS [NV] = '{
        '{6'b101010, 16'd5, 16'd3, 16'h0000},
        '{6'b111111, 16'd5, 16'd3, 16'h0001},
        '{6'b111010, 16'd5, 16'd3, 16'hFFFF},
        '{6'b001100, 16'd5, 16'd3, 16'h0005},
        '{6'b110000, 16'd5, 16'd3, 16'h0003},
        '{6'b001101, 16'd5, 16'd3, 16'hFFFA},
        '{6'b001111, 16'd5, 16'd3, 16'hFFFB},
        '{6'b011111, 16'd5, 16'd3, 16'h0006},
        '{6'b000010, 16'd5, 16'd3, 16'h0008},
        '{6'b010011, 16'd5, 16'd3, 16'h0002},
        '{6'b000111, 16'd5, 16'd3, 16'hFFFE},
        '{6'b000000, 16'd5, 16'd3, 16'h0001},
        '{6'b010101, 16'd5, 16'd3, 16'h0007}
    };

    // Independent model built from the requirement text.
    function automatic logic [15:0] model(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
        int unsigned ax, ay, r;
        ax = c[5] ? 0 : int'(x);
        if (c[4]) ax = 32'hFFFF - ax;
        ay = c[3] ? 0 : int'(y);
        if (c[2]) ay = 32'hFFFF - ay;
        if (c[1]) r = (ax + ay) % 65536;
        else      r = ax & ay;
        if (c[0]) r = 32'hFFFF - r;
        return r[15:0];
    endfunction

    task automatic apply(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
        @(posedge clk);
        code   = c;
        opnd_x = x;
        opnd_y = y;
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input logic [15:0] exp);
        logic ez, en;
        ez = (exp == 16'h0000);
        en = exp[15];
        n_chk++;
        if (result !== exp || is_zero !== ez || is_neg !== en) begin
            n_fail++;
            $display("FAIL %s code=%b x=%h y=%h: got r=%h z=%b n=%b, expected r=%h z=%b n=%b",
                     req, code, opnd_x, opnd_y, result, is_zero, is_neg, exp, ez, en);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // Idle state: all-zero inputs, AND core -> zero result, zero flag set (R6, R8)
        apply(6'b000000, 16'h0000, 16'h0000);
        check_out("R6 R8 idle", 16'h0000);

        // Table of named encodings (R11)
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].c, VECS[i].x, VECS[i].y);
            check_out("R11 table", VECS[i].exp);
        end

        // R1/R2: clear and invert order on x, y passes through via AND with ones
        apply(6'b100000, 16'hBEEF, 16'hFFFF);
        check_out("R1 clear x", 16'h0000);
        apply(6'b110000, 16'hBEEF, 16'h1234);
        check_out("R2 clear then invert x", 16'h1234);
        // R3/R4 on y
        apply(6'b001000, 16'hFFFF, 16'hBEEF);
        check_out("R3 clear y", 16'h0000);
        apply(6'b000100, 16'hFFFF, 16'h00F0);
        check_out("R4 invert y", 16'hFF0F);
        // R5: wrap to zero raises zero flag, positive overflow sets sign
        apply(6'b000010, 16'hFFFF, 16'h0001);
        check_out("R5 R8 wrap to zero", 16'h0000);
        apply(6'b000010, 16'h7FFF, 16'h0001);
        check_out("R5 R9 overflow into sign", 16'h8000);
        // R7: inverting a zero AND gives all ones and negative
        apply(6'b000001, 16'hAAAA, 16'h5555);
        check_out("R7 invert output", 16'hFFFF);
        // R10: change only operand without any clock-driven step inside the cycle
        apply(6'b000010, 16'd100, 16'd23);
        check_out("R10 first", 16'd123);
        #3 opnd_x = 16'd200;
        #1 check_out("R10 follows input", 16'd223);

        // Exhaustive control sweep with random operands (R1-R9 coverage)
        for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] rx, ry;
                rx = 16'($urandom());
                ry = 16'($urandom());
                if (k == 0) begin rx = 16'h0000; ry = 16'hFFFF; end
                if (k == 1) begin rx = 16'h8000; ry = 16'h8000; end
                apply(6'(c), rx, ry);
                check_out("R9 sweep", model(6'(c), rx, ry));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule